// File: doc/BRIEF.md
# Hit-Strip Cluster List Encoder

This block compresses one triggered event from a row of 64 detector strips into a short list of clusters. A start strobe captures a 64-bit hit vector. The block then walks the vector one strip per clock, from strip 0 upwards. Each unbroken run of set bits becomes one list entry, which holds the index of the run's lowest strip and the number of strips in the run. Strips without a hit produce nothing.

The list has a fixed number of slots. A 4-bit limit input, sampled at start, can lower the number of slots in use. Once the list is full, any later runs are dropped and a truncation flag is raised. A one-cycle done strobe marks the point where the count, the list and the flag are final. These results stay unchanged until the next start is accepted. Strip masking is done before this block, and the serialisation of the list onto a link is done after it.

Top module: `strip_cluster_encoder`

## Requirements
- R1: After reset, `done` and `truncated` are 0, `clu_count` is 0 and every list field is 0.
- R2: If `start` is accepted at clock edge e, `done` is high for exactly one cycle, in the cycle that follows edge e+64. All outputs are final in that cycle.
- R3: Entry k occupies bits `k*6 +: 6` of `clu_first` (start strip) and bits `k*7 +: 7` of `clu_len` (run length). Entries are filled in ascending strip order.
- R4: A run that includes strip 63 is closed at the end of the scan and listed. A vector with every bit set gives a single entry with start 0 and length 64.
- R5: The cap on listed clusters equals `clu_limit` when that value is between 1 and 10. A value of 0 or a value above 10 gives a cap of 10.
- R6: Runs found after the list holds cap entries are discarded, and `truncated` is set. The fields of entries at index `clu_count` and above read 0.
- R7: `truncated` stays 0 when the event has no more runs than the cap, including the case where the number of runs equals the cap exactly.
- R8: A `start` pulse while a scan is in progress is ignored. It causes no extra `done` and does not change the result.
- R9: Results hold until the next accepted start. A change to `clu_limit` after start has been accepted does not change the event that is being scanned or has finished.
- R10: `clu_count` equals the number of listed entries. A vector with no bits set gives a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture `hit_vec` and begin a scan (ignored while busy) |
| hit_vec | input | 64 | One bit per strip, bit i = strip i |
| clu_limit | input | 4 | Requested cluster cap, sampled at start |
| clu_first | output | 60 | Start strip of each entry, 6 bits per entry |
| clu_len | output | 70 | Run length of each entry, 7 bits per entry |
| clu_count | output | 4 | Number of listed entries |
| truncated | output | 1 | Runs were dropped because the cap was reached |
| done | output | 1 | One-cycle strobe when the results are final |

## Verification
The bench drives runs that reach strip 63 and a vector with every bit set. A design that forgot to close an open run at the end of the scan would lose that entry or report it one strip short. Alternating-bit vectors are scanned under several caps, including a cap of 0 and a cap above 10. These catch an off-by-one cap, a missing truncation flag, or a list written past its cap. An event whose number of runs equals the cap exactly catches a flag that is raised too early. A start pulse during a scan and a limit change after start check that a busy scan is not restarted and that the cap is latched. A design that got either wrong would show an extra done strobe or a list cut to the wrong length.

// File: rtl/clu_pkg.sv
package clu_pkg;

  typedef enum logic {ST_IDLE, ST_SCAN} scan_st_e;

  // Cap actually applied: zero or out-of-range requests fall back to the slot count.
  function automatic int unsigned eff_cap(input int unsigned lim, input int unsigned slots);
    return (lim == 0 || lim > slots) ? slots : lim;
  endfunction

endpackage

// File: rtl/clu_scan_ctrl.sv
module clu_scan_ctrl
  import clu_pkg::*;
#(
  parameter int N_STRIPS = 64,
  parameter int IDX_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [N_STRIPS-1:0] vec_i,
  output logic                accept_o,
  output logic                busy_o,
  output logic                strip_vld_o,
  output logic                strip_bit_o,
  output logic [IDX_W-1:0]    strip_idx_o,
  output logic                strip_last_o,
  output logic                done_o
);

  scan_st_e            st_q;
  logic [N_STRIPS-1:0] sh_q;
  logic [IDX_W-1:0]    idx_q;
  logic                done_q;

  assign busy_o       = (st_q == ST_SCAN);
  assign accept_o     = start_i && (st_q == ST_IDLE);
  assign strip_vld_o  = busy_o;
  assign strip_bit_o  = sh_q[0];
  assign strip_idx_o  = idx_q;
  assign strip_last_o = (idx_q == IDX_W'(N_STRIPS - 1));
  assign done_o       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          sh_q  <= vec_i;
          idx_q <= '0;
          st_q  <= ST_SCAN;
        end
        default: begin
          sh_q  <= sh_q >> 1;
          idx_q <= idx_q + IDX_W'(1);
          if (strip_last_o) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/clu_run_track.sv
module clu_run_track #(
  parameter int IDX_W = 6,
  parameter int LEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             vld_i,
  input  logic             bit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             last_i,
  output logic             emit_o,
  output logic [IDX_W-1:0] emit_first_o,
  output logic [LEN_W-1:0] emit_len_o
);

  logic             in_run_q;
  logic [IDX_W-1:0] first_q;
  logic [LEN_W-1:0] len_q;

  // A run closes on the first clear strip, or at the final strip if it is still open.
  always_comb begin
    emit_o       = vld_i && ((in_run_q && !bit_i) || (last_i && bit_i));
    emit_first_o = in_run_q ? first_q : idx_i;
    emit_len_o   = in_run_q ? (bit_i ? len_q + LEN_W'(1) : len_q) : LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_run_q <= 1'b0;
      first_q  <= '0;
      len_q    <= '0;
    end else if (clear_i) begin
      in_run_q <= 1'b0;
      first_q  <= '0;
      len_q    <= '0;
    end else if (vld_i) begin
      if (bit_i && !last_i) begin
        if (!in_run_q) begin
          in_run_q <= 1'b1;
          first_q  <= idx_i;
          len_q    <= LEN_W'(1);
        end else begin
          len_q <= len_q + LEN_W'(1);
        end
      end else begin
        in_run_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/clu_list_store.sv
module clu_list_store
  import clu_pkg::*;
#(
  parameter int MAX_CLU = 10,
  parameter int IDX_W   = 6,
  parameter int LEN_W   = 7,
  parameter int LIM_W   = 4,
  parameter int CNT_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic [LIM_W-1:0]         limit_i,
  input  logic                     emit_i,
  input  logic [IDX_W-1:0]         first_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic [MAX_CLU*IDX_W-1:0] firsts_o,
  output logic [MAX_CLU*LEN_W-1:0] lens_o,
  output logic [CNT_W-1:0]         count_o,
  output logic                     trunc_o,
  output logic                     full_o,
  output logic [CNT_W-1:0]         cap_o
);

  logic [CNT_W-1:0] cap_q, count_q;
  logic             trunc_q, wr_en;

  assign full_o  = (count_q >= cap_q);
  assign wr_en   = emit_i && !full_o;
  assign count_o = count_q;
  assign trunc_o = trunc_q;
  assign cap_o   = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= CNT_W'(MAX_CLU);
      count_q <= '0;
      trunc_q <= 1'b0;
    end else if (clear_i) begin
      cap_q   <= CNT_W'(eff_cap(int'(limit_i), MAX_CLU));
      count_q <= '0;
      trunc_q <= 1'b0;
    end else if (wr_en) begin
      count_q <= count_q + CNT_W'(1);
    end else if (emit_i) begin
      trunc_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < MAX_CLU; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        firsts_o[g*IDX_W +: IDX_W] <= '0;
        lens_o[g*LEN_W +: LEN_W]   <= '0;
      end else if (clear_i) begin
        firsts_o[g*IDX_W +: IDX_W] <= '0;
        lens_o[g*LEN_W +: LEN_W]   <= '0;
      end else if (wr_en && count_q == CNT_W'(g)) begin
        firsts_o[g*IDX_W +: IDX_W] <= first_i;
        lens_o[g*LEN_W +: LEN_W]   <= len_i;
      end
    end
  end

endmodule

// File: rtl/strip_cluster_encoder.sv
module strip_cluster_encoder #(
  parameter int N_STRIPS = 64,
  parameter int MAX_CLU  = 10,
  parameter int LIM_W    = 4,
  localparam int IDX_W   = $clog2(N_STRIPS),
  localparam int LEN_W   = $clog2(N_STRIPS) + 1,
  localparam int CNT_W   = $clog2(MAX_CLU + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [N_STRIPS-1:0]      hit_vec,
  input  logic [LIM_W-1:0]         clu_limit,
  output logic [MAX_CLU*IDX_W-1:0] clu_first,
  output logic [MAX_CLU*LEN_W-1:0] clu_len,
  output logic [CNT_W-1:0]         clu_count,
  output logic                     truncated,
  output logic                     done
);

  // Internal events, named for the bound checker.
  logic             accept, busy, strip_vld, strip_bit, strip_last;
  logic [IDX_W-1:0] strip_idx;
  logic             emit, store_full;
  logic [IDX_W-1:0] emit_first;
  logic [LEN_W-1:0] emit_len;
  logic [CNT_W-1:0] cap;

  clu_scan_ctrl #(.N_STRIPS(N_STRIPS), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .vec_i(hit_vec),
    .accept_o(accept), .busy_o(busy), .strip_vld_o(strip_vld),
    .strip_bit_o(strip_bit), .strip_idx_o(strip_idx),
    .strip_last_o(strip_last), .done_o(done)
  );

  clu_run_track #(.IDX_W(IDX_W), .LEN_W(LEN_W)) run_i (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .vld_i(strip_vld),
    .bit_i(strip_bit), .idx_i(strip_idx), .last_i(strip_last),
    .emit_o(emit), .emit_first_o(emit_first), .emit_len_o(emit_len)
  );

  clu_list_store #(.MAX_CLU(MAX_CLU), .IDX_W(IDX_W), .LEN_W(LEN_W),
                   .LIM_W(LIM_W), .CNT_W(CNT_W)) store_i (
    .clk(clk), .rst_n(rst_n), .clear_i(accept), .limit_i(clu_limit),
    .emit_i(emit), .first_i(emit_first), .len_i(emit_len),
    .firsts_o(clu_first), .lens_o(clu_len), .count_o(clu_count),
    .trunc_o(truncated), .full_o(store_full), .cap_o(cap)
  );

endmodule

// File: rtl/clu_encoder_chk.sv
module clu_encoder_chk #(
  parameter int N_STRIPS = 64,
  parameter int MAX_CLU  = 10,
  parameter int CNT_W    = 4,
  parameter int FW       = 60
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic             busy,
  input logic             emit,
  input logic             store_full,
  input logic [CNT_W-1:0] cap,
  input logic [CNT_W-1:0] clu_count,
  input logic [FW-1:0]    clu_first,
  input logic             truncated,
  input logic             done
);

  localparam int SC_W = $clog2(N_STRIPS + 2);
  logic [SC_W-1:0] scan_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scan_cnt <= '0;
    else if (accept)   scan_cnt <= '0;
    else if (busy)     scan_cnt <= scan_cnt + SC_W'(1);
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scan_cnt == SC_W'(N_STRIPS)));

  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    clu_count <= cap);

  a_r6_trunc_full: assert property (@(posedge clk) disable iff (!rst_n)
    truncated |-> (clu_count == cap));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !store_full) |=> (clu_count == $past(clu_count) + CNT_W'(1)));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !accept) |=> ($stable(clu_count) && $stable(truncated) && $stable(clu_first)));

endmodule

bind strip_cluster_encoder clu_encoder_chk #(
  .N_STRIPS(N_STRIPS), .MAX_CLU(MAX_CLU), .CNT_W(CNT_W), .FW(MAX_CLU*IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .accept(accept), .busy(busy), .emit(emit),
  .store_full(store_full), .cap(cap), .clu_count(clu_count),
  .clu_first(clu_first), .truncated(truncated), .done(done)
);

// File: tb/strip_cluster_encoder_tb.sv
module strip_cluster_encoder_tb_top;

  localparam int N = 64, MC = 10;

  logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [N-1:0]  hit_vec = '0;
  logic [3:0]    clu_limit = '0;
  logic [MC*6-1:0] clu_first;
  logic [MC*7-1:0] clu_len;
  logic [3:0]    clu_count;
  logic          truncated, done;

  always #5 clk = ~clk;

  strip_cluster_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_vec(hit_vec),
    .clu_limit(clu_limit), .clu_first(clu_first), .clu_len(clu_len),
    .clu_count(clu_count), .truncated(truncated), .done(done)
  );

  typedef struct {
    logic [MC*6-1:0] f;
    logic [MC*7-1:0] l;
    int              cnt;
    bit              tr;
    longint          cyc;
    string           rq;
  } exp_t;

  exp_t   q[$];
  exp_t   last_e;
  int     checks = 0, errors = 0;
  longint cyc = 0;
  bit     prev_done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, ex);
    end
  endtask

  // Independent model: walk the strips, measure each run, apply the cap.
  function automatic exp_t model(input logic [N-1:0] v, input int lim, input string rq);
    exp_t e;
    int cap = (lim == 0 || lim > MC) ? MC : lim;
    int i = 0;
    e.f = '0; e.l = '0; e.cnt = 0; e.tr = 0; e.cyc = 0; e.rq = rq;
    while (i < N) begin
      if (!v[i]) i++;
      else begin
        int s;
        s = i;
        while (i < N && v[i]) i++;
        if (e.cnt < cap) begin
          e.f[e.cnt*6 +: 6] = 6'(s);
          e.l[e.cnt*7 +: 7] = 7'(i - s);
          e.cnt++;
        end else e.tr = 1;
      end
    end
    return e;
  endfunction

  task automatic drive(input logic [N-1:0] v, input int lim, input string rq);
    exp_t e;
    e = model(v, lim, rq);
    @(negedge clk);
    e.cyc = cyc + 65;
    q.push_back(e);
    hit_vec   = v;
    clu_limit = 4'(lim);
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pop the expected item at each done strobe and compare.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        chk(!prev_done, "R2", "done longer than one cycle", 1, 0);
        if (q.size() == 0) chk(0, "R8", "done with no pending event", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          last_e = e;
          chk(cyc == e.cyc, {e.rq, " R2"}, "done cycle", cyc, e.cyc);
          chk(int'(clu_count) == e.cnt, {e.rq, " R10"}, "count", clu_count, e.cnt);
          chk(truncated == e.tr, {e.rq, " R6/R7 flag"}, "truncated", truncated, e.tr);
          for (int k = 0; k < MC; k++) begin
            chk(clu_first[k*6 +: 6] == e.f[k*6 +: 6], {e.rq, " R3"},
                $sformatf("first[%0d]", k), clu_first[k*6 +: 6], e.f[k*6 +: 6]);
            chk(clu_len[k*7 +: 7] == e.l[k*7 +: 7], {e.rq, " R3"},
                $sformatf("len[%0d]", k), clu_len[k*7 +: 7], e.l[k*7 +: 7]);
          end
        end
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] alt;
    alt = {32{2'b01}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == 0, "R1", "done", done, 0);
    chk(truncated == 0, "R1", "truncated", truncated, 0);
    chk(clu_count == 0, "R1", "count", clu_count, 0);
    chk(clu_first == '0 && clu_len == '0, "R1", "list nonzero", 1, 0);

    drive('0, 0, "R10 empty");              wait_idle();
    drive(64'h20, 0, "R3 single");          wait_idle();
    drive('1, 0, "R4 full row");            wait_idle();
    drive(64'h8000_0000_0000_0000, 0, "R4 strip63"); wait_idle();
    drive(64'hF000_0000_0000_0F01, 0, "R4 tail run"); wait_idle();
    drive(alt, 0, "R5 lim0 R6");            wait_idle();
    drive(alt, 3, "R5 lim3 R6");            wait_idle();
    drive(alt, 12, "R5 lim12");             wait_idle();
    drive(64'h0000_0F00_00F0_1003, 4, "R7 exact cap"); wait_idle();
    drive(64'h3, 1, "R7 cap1");             wait_idle();

    // R8: a second start during the scan must be ignored
    drive(64'h0C00_0000_0000_0070, 0, "R8 busy start");
    repeat (10) @(negedge clk);
    hit_vec = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (70) @(negedge clk);
    chk(q.size() == 0, "R8", "pending items", q.size(), 0);

    // R9: limit changed in mid-scan is not applied
    drive(alt, 2, "R9 latched lim");
    repeat (5) @(negedge clk);
    clu_limit = 4'd9;
    wait_idle();

    // R9: results hold after done while inputs move
    clu_limit = 4'd1; hit_vec = 64'h5;
    repeat (20) @(negedge clk);
    chk(int'(clu_count) == last_e.cnt, "R9", "count held", clu_count, last_e.cnt);
    chk(clu_first == last_e.f, "R9", "first list held", 0, 0);
    chk(clu_len == last_e.l, "R9", "len list held", 0, 0);
    chk(truncated == last_e.tr, "R9", "flag held", truncated, last_e.tr);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule